// File: doc/BRIEF.md
# Radix-2 FFT Address and Twiddle Angle Sequencer

This block drives an in-place radix-2 FFT of N = 2^n points and needs no twiddle or angle table. A start pulse begins a transform. After that, every cycle with the step enable high issues one butterfly. For that butterfly the block gives the data memory address, the twiddle rotation angle and the stage index, and it raises a valid strobe. The sequence covers n stages of N/2 butterflies each. A one-cycle done flag follows the final butterfly.

The butterfly index B is an (n-1)-bit counter. The memory address is B rotated right by the stage number p. The angle comes from an accumulator that gains one basic angle (2π/N) per issued butterfly and clears at every stage boundary. A gated latch takes the accumulator value only when the low p bits of B are all zero, and holds it for the other butterflies.

The angle is a binary phase word of `ANGLE_W` bits, in which one full turn equals 2^ANGLE_W. A rotator downstream uses this word directly. The data RAM, the butterfly arithmetic and the rotator are outside this block.

Top module: `fft_addr_angle_seq`

## Requirements
- R1: After reset, `bflyValid` and `done` are 0, and `addr`, `angle` and `stage` are 0.
- R2: A `start` pulse while idle begins a transform at stage 0 with B = 0. The transform issues exactly N/2 butterflies in each of n stages, with B ascending from 0 to N/2-1 inside each stage.
- R3: The address of butterfly B in stage p equals B, as an (n-1)-bit value, rotated right by p bit positions. Output bit i is B bit ((i+p) mod (n-1)).
- R4: The angle of butterfly B in stage p equals (B with its low p bits cleared) multiplied by 2^(ANGLE_W-n). This is that multiple of 2π/N written as a phase word.
- R5: In stage 0 the angle of butterfly B is B·2^(ANGLE_W-n). In the last stage (p = n-1) every angle is 0.
- R6: A cycle with `stepEn` low issues nothing: `bflyValid` is 0 in the next cycle. The sequence then resumes at the butterfly that was not issued.
- R7: `done` is high for exactly one cycle: the cycle right after the cycle in which the final butterfly (last stage, B = N/2-1) is presented.
- R8: A `start` pulse during a transform is ignored. The sequence continues unchanged.
- R9: `stage` shows the stage index p of the butterfly being presented.
- R10: The outputs for a butterfly appear one cycle after the clock edge that accepted its step. `bflyValid` is high in that cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transform (ignored while one is running) |
| stepEn | input | 1 | Issue one butterfly this cycle |
| addr | output | LOG2N-1 | Data memory address of the presented butterfly |
| angle | output | ANGLE_W | Twiddle rotation angle, full turn = 2^ANGLE_W |
| stage | output | STAGE_W | Stage index of the presented butterfly |
| bflyValid | output | 1 | Outputs describe a newly issued butterfly |
| done | output | 1 | One-cycle pulse after the final butterfly |

## Verification
The hardest case to reach is a stall that falls on a butterfly whose low p bits are non-zero. In that case the latch must keep its angle while the accumulator and the counter stand still, and it must take the right value when stepping resumes. The bench reaches it with a repeating enable pattern whose period does not divide the stage length, so stalls land on every residue of B in every stage. Stage boundaries with the last stage's all-zero angles are checked the same way, for three transform sizes run side by side, and against a model built only from bit rotation and masking.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic advance;   // one butterfly issued this cycle
    logic begin_;    // a new transform is being loaded
    logic lowZero;   // low p bits of the counter are zero
    logic cntZero;   // counter is at the first butterfly of a stage
    logic cntMax;    // counter is at the last butterfly of a stage
  } seqStrobes_t;

endpackage

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
  import fft_seq_pkg::*;
#(
  parameter int LOG2N   = 4,
  parameter int CNT_W   = LOG2N - 1,
  parameter int STAGE_W = $clog2(LOG2N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               stepEn,
  output seqStrobes_t        strb,
  output logic [CNT_W-1:0]   cnt,
  output logic [STAGE_W-1:0] stageCur,
  output logic               done
);

  localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(LOG2N - 1);
  localparam logic [CNT_W-1:0]   CNT_MAX    = {CNT_W{1'b1}};

  logic running;
  logic finalQ;
  logic doneQ;
  logic [CNT_W-1:0] lowMask;
  logic lastAdv;

  // Mask with the low stageCur bits set
  always_comb begin
    lowMask = '0;
    for (int i = 0; i < CNT_W; i++) begin
      lowMask[i] = (i < int'(stageCur));
    end
  end

  always_comb begin
    strb.advance = running && stepEn;
    strb.begin_  = start && !running;
    strb.lowZero = ((cnt & lowMask) == '0);
    strb.cntZero = (cnt == '0);
    strb.cntMax  = (cnt == CNT_MAX);
  end

  assign lastAdv = strb.advance && strb.cntMax && (stageCur == LAST_STAGE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      cnt      <= '0;
      stageCur <= '0;
      finalQ   <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      finalQ <= lastAdv;
      doneQ  <= finalQ;
      if (strb.advance) begin
        if (strb.cntMax) begin
          cnt <= '0;
          if (stageCur == LAST_STAGE) begin
            running  <= 1'b0;
            stageCur <= '0;
          end else begin
            stageCur <= stageCur + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (strb.begin_) begin
        running  <= 1'b1;
        cnt      <= '0;
        stageCur <= '0;
      end
    end
  end

  assign done = doneQ;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.cntMax) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !stepEn) |=> ($stable(cnt) && $stable(stageCur)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R8
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && !lastAdv) |=> running);

endmodule

// File: rtl/fft_seq_dpath.sv
module fft_seq_dpath
  import fft_seq_pkg::*;
#(
  parameter int LOG2N   = 4,
  parameter int ANGLE_W = 16,
  parameter int CNT_W   = LOG2N - 1,
  parameter int STAGE_W = $clog2(LOG2N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobes_t        strb,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [STAGE_W-1:0] stageCur,
  output logic [CNT_W-1:0]   addr,
  output logic [ANGLE_W-1:0] angle,
  output logic [STAGE_W-1:0] stage,
  output logic               bflyValid
);

  localparam int ANGLE_SH = ANGLE_W - LOG2N;
  localparam logic [ANGLE_W-1:0] STEP = ANGLE_W'(1) << ANGLE_SH;

  logic [ANGLE_W-1:0] acc;
  logic [ANGLE_W-1:0] angleQ;
  logic [CNT_W-1:0]   rotAddr;
  logic [CNT_W-1:0]   addrQ;
  logic [STAGE_W-1:0] stageQ;
  logic               validQ;

  // Rotate the counter right by the stage index
  always_comb begin
    rotAddr = '0;
    for (int i = 0; i < CNT_W; i++) begin
      int j;
      j = i + int'(stageCur);
      if (j >= CNT_W) j = j - CNT_W;
      rotAddr[i] = cnt[j];
    end
  end

  // Accumulator: one basic angle per issued butterfly, cleared at stage wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strb.begin_) begin
      acc <= '0;
    end else if (strb.advance) begin
      acc <= strb.cntMax ? '0 : acc + STEP;
    end
  end

  // Gated latch and presented outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      angleQ <= '0;
      addrQ  <= '0;
      stageQ <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.advance;
      if (strb.advance) begin
        addrQ  <= rotAddr;
        stageQ <= stageCur;
        if (strb.lowZero) angleQ <= acc;
      end
    end
  end

  assign addr      = addrQ;
  assign angle     = angleQ;
  assign stage     = stageQ;
  assign bflyValid = validQ;

  // R4
  angle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.lowZero) |=> $stable(angleQ));

  // R5
  stage_first_angle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.cntZero) |=> (angleQ == '0));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> validQ);

  // R6
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> !validQ);

endmodule

// File: rtl/fft_addr_angle_seq.sv
module fft_addr_angle_seq
  import fft_seq_pkg::*;
#(
  parameter int N_POINTS = 16,
  parameter int ANGLE_W  = 16,
  localparam int LOG2N   = $clog2(N_POINTS),
  localparam int CNT_W   = LOG2N - 1,
  localparam int STAGE_W = $clog2(LOG2N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               stepEn,
  output logic [CNT_W-1:0]   addr,
  output logic [ANGLE_W-1:0] angle,
  output logic [STAGE_W-1:0] stage,
  output logic               bflyValid,
  output logic               done
);

  seqStrobes_t        strb;
  logic [CNT_W-1:0]   cnt;
  logic [STAGE_W-1:0] stageCur;

  initial begin
    if (N_POINTS < 8 || (1 << LOG2N) != N_POINTS || ANGLE_W < LOG2N)
      $error("fft_addr_angle_seq: bad parameters");
  end

  fft_seq_ctrl #(.LOG2N(LOG2N), .CNT_W(CNT_W), .STAGE_W(STAGE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn),
    .strb(strb), .cnt(cnt), .stageCur(stageCur), .done(done)
  );

  fft_seq_dpath #(.LOG2N(LOG2N), .ANGLE_W(ANGLE_W), .CNT_W(CNT_W),
                  .STAGE_W(STAGE_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .stageCur(stageCur),
    .addr(addr), .angle(angle), .stage(stage), .bflyValid(bflyValid)
  );

endmodule

// File: tb/test_fft_addr_angle_seq.sv
`timescale 1ns/1ps
module test_fft_addr_angle_seq;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN, start, stepEn;
  always #2 clk = ~clk;

  // Three sizes side by side: 16, 8 and 64 points
  logic [2:0] a0; logic [W-1:0] g0; logic [1:0] s0; logic v0, d0;
  logic [1:0] a1; logic [W-1:0] g1; logic [1:0] s1; logic v1, d1;
  logic [4:0] a2; logic [W-1:0] g2; logic [2:0] s2; logic v2, d2;

  fft_addr_angle_seq #(.N_POINTS(16), .ANGLE_W(W)) i_fft_addr_angle_seq (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn),
    .addr(a0), .angle(g0), .stage(s0), .bflyValid(v0), .done(d0));
  fft_addr_angle_seq #(.N_POINTS(8), .ANGLE_W(W)) i_fft_addr_angle_seq_n8 (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn),
    .addr(a1), .angle(g1), .stage(s1), .bflyValid(v1), .done(d1));
  fft_addr_angle_seq #(.N_POINTS(64), .ANGLE_W(W)) i_fft_addr_angle_seq_n64 (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn),
    .addr(a2), .angle(g2), .stage(s2), .bflyValid(v2), .done(d2));

  int nTests = 0;
  int nFail  = 0;
  int runM[3], bM[3], pM[3], finM[3];

  function automatic int lnOf(int i);
    return (i == 0) ? 4 : (i == 1) ? 3 : 6;
  endfunction

  function automatic int rotr(int b, int p, int w);
    return ((b >> p) | (b << (w - p))) & ((1 << w) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic getOut(input int i, output int ad, output int an, output int st,
                        output int va, output int dn);
    case (i)
      0: begin ad = int'(a0); an = int'(g0); st = int'(s0); va = int'(v0); dn = int'(d0); end
      1: begin ad = int'(a1); an = int'(g1); st = int'(s1); va = int'(v1); dn = int'(d1); end
      default: begin ad = int'(a2); an = int'(g2); st = int'(s2); va = int'(v2); dn = int'(d2); end
    endcase
  endtask

  // One clock: drive at the falling edge, update the model, sample after the rising edge
  task automatic cycle(input bit s, input bit e);
    @(negedge clk);
    start = s; stepEn = e;
    @(posedge clk);
    #1;
    for (int i = 0; i < 3; i++) begin
      int n, w, ad, an, st, va, dn, expDone;
      bit adv, last, wasRun;
      n = lnOf(i); w = n - 1;
      getOut(i, ad, an, st, va, dn);
      wasRun = (runM[i] != 0);
      adv = wasRun && e;
      expDone = finM[i];
      finM[i] = 0;
      if (adv) begin
        int ea, eg;
        ea = rotr(bM[i], pM[i], w);
        eg = ((bM[i] & ~((1 << pM[i]) - 1)) << (W - n)) & ((1 << W) - 1);
        chk(ad == ea, s ? "R8 addr continues" : "R3 addr", ad, ea);
        chk(an == eg, "R4 angle", an, eg);
        chk(st == pM[i], "R9 stage", st, pM[i]);
        if (pM[i] == 0) chk(an == (bM[i] << (W - n)), "R5 stage0 angle", an, bM[i] << (W - n));
        if (pM[i] == n - 1) chk(an == 0, "R5 last-stage angle", an, 0);
        last = (bM[i] == (1 << w) - 1) && (pM[i] == n - 1);
        if (bM[i] == (1 << w) - 1) begin
          bM[i] = 0;
          if (pM[i] == n - 1) runM[i] = 0; else pM[i]++;
        end else begin
          bM[i]++;
        end
        finM[i] = last ? 1 : 0;
      end else if (s && !wasRun) begin
        runM[i] = 1; bM[i] = 0; pM[i] = 0;
      end
      chk(va == int'(adv), "R2/R6/R10 valid", va, int'(adv));
      chk(dn == expDone, "R7 done", dn, expDone);
    end
  endtask

  task automatic runUntilIdle(input int mode);
    for (int k = 0; k < 4000; k++) begin
      bit e;
      if (runM[0] == 0 && runM[1] == 0 && runM[2] == 0 &&
          finM[0] == 0 && finM[1] == 0 && finM[2] == 0) break;
      e = (mode == 0) ? 1'b1 : ((k % 5) != 2 && (k % 7) != 4);
      cycle(1'b0, e);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; start = 1'b0; stepEn = 1'b0;
    for (int i = 0; i < 3; i++) begin runM[i] = 0; bM[i] = 0; pM[i] = 0; finM[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      int ad, an, st, va, dn;
      getOut(i, ad, an, st, va, dn);
      chk(ad == 0 && an == 0 && st == 0, "R1 reset outputs", ad + an + st, 0);
      chk(va == 0 && dn == 0, "R1 reset strobes", va + dn, 0);
    end
  endtask

  // R2: full transform, step every cycle
  task automatic testFullRun();
    cycle(1'b1, 1'b1);
    runUntilIdle(0);
  endtask

  // R6: irregular stalls landing on every residue of B
  task automatic testStalls();
    cycle(1'b1, 1'b0);
    runUntilIdle(1);
  endtask

  // R8: start pulses while running are ignored
  task automatic testStartIgnored();
    cycle(1'b1, 1'b1);
    for (int k = 0; k < 9; k++) cycle(k[0], 1'b1);
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b1);
    runUntilIdle(0);
  endtask

  // R6/R2: stepping while idle issues nothing
  task automatic testIdle();
    for (int k = 0; k < 6; k++) cycle(1'b0, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    testReset();
    testFullRun();
    testIdle();
    testStalls();
    testStartIgnored();
    testIdle();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule